// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings that steer a clock synthesizer's dividers: a 9-bit feedback count M, a 2-bit post-divider select N and a 3-bit test selector T. The settings arrive in one of two ways. A three-wire serial port (data, shift clock, load strobe) fills a 14-bit shift register. A parallel bus carries M and N and is qualified by a level-sensitive parallel strobe.

All strobes and data are brought into a single system clock domain through two-flop synchronisers, and the transparent configuration latches are modelled as registers in that domain. While the parallel strobe is low, the parallel bus wins. In that state the held M and N follow the bus, and T is forced to zero. The serial port only takes effect once the parallel strobe is high, which is the usual power-up order: parallel first, then serial retuning. The most significant bit of the shift register is brought out for a test-output selector.

There is no data stream here, so there is no valid/ready handshake. Every pin is a plain control or status level.

Top module: `divcfg_port`

## Requirements
- R1: Each rising edge of the serial clock shifts the serial data bit into bit 0 of the 14-bit shift register, and the rest of the register moves up by one place. `sr_msb` always shows bit 13.
- R2: A frame is sent as T2, T1, T0, N1, N0, M8 … M0, with the first bit sent first. After 14 shifts, T is in bits 13..11, N in bits 10..9 and M in bits 8..0.
- R3: While the parallel strobe is high and the serial load strobe is high, `m_val`, `n_sel` and `t_sel` follow the shift register fields. When the serial load strobe falls, the values present at that moment are kept.
- R4: While the parallel strobe is low, `m_val` and `n_sel` follow `par_m` and `par_n`. When the parallel strobe rises, the bus values present at that moment are kept.
- R5: While the parallel strobe is low, `t_sel` is 000 and the serial load strobe has no effect.
- R6: While the parallel strobe is high and the serial load strobe is low, the outputs hold. Parallel bus changes and serial shifting do not alter them.
- R7: After reset, `m_val`, `n_sel`, `t_sel` and the shift register are all zero.
- R8: An input change made between clock edges reaches the outputs on the third rising `clk` edge after it: two synchroniser stages plus one register.
- R9: When more than 14 bits are shifted, only the last 14 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load strobe, transparent when high |
| par_ld | input | 1 | Parallel strobe, transparent when low, has priority |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel post-divider select |
| m_val | output | 9 | Held feedback divider value |
| n_sel | output | 2 | Held post-divider select |
| t_sel | output | 3 | Held test selector |
| sr_msb | output | 1 | Shift register bit 13 |

## Verification
The assertions assume that the serial data is stable around each serial clock rise, and that every strobe and serial clock level lasts at least two system clocks, so that the synchronised copies never skip an edge. The stimulus holds each serial clock phase and each strobe level for three or more clocks. It changes data only while the serial clock is low, and it always drives inputs on the falling edge of `clk`, so the synchronisers never see an edge that coincides with a change.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int DEF_M_W = 9;
  localparam int DEF_N_W = 2;
  localparam int DEF_T_W = 3;

  typedef enum logic [1:0] {
    LM_PARALLEL = 2'd0,
    LM_SERIAL   = 2'd1,
    LM_HOLD     = 2'd2
  } latch_mode_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_q,
  input  logic          sdat_q,
  output logic [FW-1:0] sr,
  output logic          shift_pulse
);
  logic sclk_prev;

  assign shift_pulse = sclk_q & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sr        <= '0;
    end else begin
      sclk_prev <= sclk_q;
      if (shift_pulse) sr <= {sr[FW-2:0], sdat_q};
    end
  end
endmodule

// File: rtl/divcfg_hold.sv
module divcfg_hold
  import divcfg_pkg::*;
#(
  parameter int M_W = DEF_M_W,
  parameter int N_W = DEF_N_W,
  parameter int T_W = DEF_T_W,
  localparam int FW = M_W + N_W + T_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_q,
  input  logic           ser_q,
  input  logic [M_W-1:0] pm_q,
  input  logic [N_W-1:0] pn_q,
  input  logic [FW-1:0]  sr,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic [T_W-1:0] t_sel
);
  latch_mode_e mode;

  always_comb begin
    if (!par_q)     mode = LM_PARALLEL;
    else if (ser_q) mode = LM_SERIAL;
    else            mode = LM_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val <= '0;
      n_sel <= '0;
      t_sel <= '0;
    end else begin
      case (mode)
        LM_PARALLEL: begin
          m_val <= pm_q;
          n_sel <= pn_q;
          t_sel <= '0;
        end
        LM_SERIAL: begin
          m_val <= sr[M_W-1:0];
          n_sel <= sr[M_W+N_W-1:M_W];
          t_sel <= sr[FW-1:M_W+N_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port
  import divcfg_pkg::*;
#(
  parameter int M_W = DEF_M_W,
  parameter int N_W = DEF_N_W,
  parameter int T_W = DEF_T_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           par_ld,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic [T_W-1:0] t_sel,
  output logic           sr_msb
);
  localparam int FW = M_W + N_W + T_W;
  localparam int SW = 4 + M_W + N_W;

  logic [SW-1:0]  sync_q;
  logic           sclk_q, sdat_q, ser_q, par_q;
  logic [M_W-1:0] pm_q;
  logic [N_W-1:0] pn_q;
  logic [FW-1:0]  sr;
  logic           shift_pulse;

  divcfg_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_clk, ser_dat, ser_ld, par_ld, par_m, par_n}),
    .q    (sync_q)
  );

  assign {sclk_q, sdat_q, ser_q, par_q, pm_q, pn_q} = sync_q;

  divcfg_shift #(.FW(FW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_q     (sclk_q),
    .sdat_q     (sdat_q),
    .sr         (sr),
    .shift_pulse(shift_pulse)
  );

  divcfg_hold #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .par_q(par_q),
    .ser_q(ser_q),
    .pm_q (pm_q),
    .pn_q (pn_q),
    .sr   (sr),
    .m_val(m_val),
    .n_sel(n_sel),
    .t_sel(t_sel)
  );

  assign sr_msb = sr[FW-1];
endmodule

// File: rtl/divcfg_port_chk.sv
module divcfg_port_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int FW = M_W + N_W + T_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_q,
  input logic           ser_q,
  input logic           shift_pulse,
  input logic [FW-1:0]  sr,
  input logic [M_W-1:0] pm_q,
  input logic [M_W-1:0] m_val,
  input logic [N_W-1:0] n_sel,
  input logic [T_W-1:0] t_sel
);
  assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> sr[FW-1:1] == $past(sr[FW-2:0]));

  assert_shift_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(sr));

  assert_serial_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && ser_q) |=> (t_sel == $past(sr[FW-1:M_W+N_W])) && (m_val == $past(sr[M_W-1:0])));

  assert_par_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !par_q |=> m_val == $past(pm_q));

  assert_test_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !par_q |=> t_sel == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && !ser_q) |=> $stable({m_val, n_sel, t_sel}));
endmodule

bind divcfg_port divcfg_port_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_q      (par_q),
  .ser_q      (ser_q),
  .shift_pulse(shift_pulse),
  .sr         (sr),
  .pm_q       (pm_q),
  .m_val      (m_val),
  .n_sel      (n_sel),
  .t_sel      (t_sel)
);

// File: tb/sim_divcfg_port.sv
module sim_divcfg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] m_val;
  logic [1:0] n_sel;
  logic [2:0] t_sel;
  logic       sr_msb;

  always #10 clk = ~clk;

  divcfg_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
    .m_val(m_val), .n_sel(n_sel), .t_sel(t_sel), .sr_msb(sr_msb)
  );

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       msb;
    string      tag;
  } exp_t;

  exp_t  exp_q[$];
  event  probe;
  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 1'b0;
  logic [13:0] model_sr = '0;

  // monitor: compares the outputs against the oldest expected item
  initial begin
    forever begin
      @(probe);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (m_val !== e.m || n_sel !== e.n || t_sel !== e.t || sr_msb !== e.msb) begin
          n_fails++;
          $display("FAIL %s: got m=%h n=%h t=%h msb=%b, expected m=%h n=%h t=%h msb=%b",
                   e.tag, m_val, n_sel, t_sel, sr_msb, e.m, e.n, e.t, e.msb);
        end
      end
    end
  end

  task automatic expect_now(input logic [8:0] m, input logic [1:0] n,
                            input logic [2:0] t, input string tag);
    exp_t e;
    e.m = m; e.n = n; e.t = t; e.msb = model_sr[13]; e.tag = tag;
    exp_q.push_back(e);
    ->probe;
    #1;
  endtask

  task automatic wait_clk(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(3);
    ser_clk = 1'b1;
    wait_clk(3);
    ser_clk = 1'b0;
    wait_clk(3);
    model_sr = {model_sr[12:0], b};
  endtask

  task automatic send_frame(input logic [2:0] t, input logic [8:0] m, input logic [1:0] n);
    logic [13:0] f;
    f = {t, n, m};
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_sload();
    ser_ld = 1'b1;
    wait_clk(4);
    ser_ld = 1'b0;
    wait_clk(5);
  endtask

  initial begin
    wait_clk(3);
    // R7: reset state
    expect_now(9'h000, 2'b00, 3'b000, "R7 reset values");
    rst_n = 1'b1;
    wait_clk(2);

    // R4: parallel strobe low, outputs follow the bus, T forced to zero
    par_m = 9'h105; par_n = 2'b01;
    wait_clk(5);
    expect_now(9'h105, 2'b01, 3'b000, "R4 follow bus");

    // R8: latency, value changes on the third clock edge after the change
    par_m = 9'h0C3; par_n = 2'b10;
    wait_clk(2);
    expect_now(9'h105, 2'b01, 3'b000, "R8 not yet after two edges");
    wait_clk(1);
    expect_now(9'h0C3, 2'b10, 3'b000, "R8 visible after three edges");

    // R4: rising parallel strobe keeps bus value; R6: later bus changes ignored
    par_ld = 1'b1;
    wait_clk(5);
    par_m = 9'h1FF; par_n = 2'b11;
    wait_clk(6);
    expect_now(9'h0C3, 2'b10, 3'b000, "R6 bus change ignored while held");

    // R1/R2/R6: shift a frame, outputs untouched before load
    send_frame(3'b101, 9'h0AB, 2'b10);
    expect_now(9'h0C3, 2'b10, 3'b000, "R6 shifting leaves outputs, R1 msb is T2");

    // R2/R3: serial load moves fields
    pulse_sload();
    expect_now(9'h0AB, 2'b10, 3'b101, "R2 R3 frame fields loaded");

    // R3/R9: transparent while serial strobe high, extra shift drops oldest bit
    ser_ld = 1'b1;
    wait_clk(4);
    send_bit(1'b1);
    wait_clk(3);
    expect_now(model_sr[8:0], model_sr[10:9], model_sr[13:11], "R3 R9 transparent follow");
    ser_ld = 1'b0;
    wait_clk(5);
    begin
      logic [13:0] kept;
      kept = model_sr;
      send_bit(1'b0);
      wait_clk(3);
      expect_now(kept[8:0], kept[10:9], kept[13:11], "R3 held after strobe fall");
    end

    // second complete frame with different pattern
    send_frame(3'b011, 9'h156, 2'b01);
    pulse_sload();
    expect_now(9'h156, 2'b01, 3'b011, "R2 second frame");

    // R5: parallel low overrides serial load and clears T
    par_m = 9'h022; par_n = 2'b00;
    ser_ld = 1'b1;
    par_ld = 1'b0;
    wait_clk(6);
    expect_now(9'h022, 2'b00, 3'b000, "R5 parallel priority T cleared");
    ser_ld = 1'b0;
    wait_clk(2);
    par_ld = 1'b1;
    wait_clk(5);
    par_m = 9'h111;
    wait_clk(5);
    expect_now(9'h022, 2'b00, 3'b000, "R4 value kept at strobe rise");

    // R5: serial strobe while parallel low has no effect on T
    par_ld = 1'b0;
    wait_clk(3);
    pulse_sload();
    expect_now(9'h111, 2'b00, 3'b000, "R5 serial strobe ignored");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule